// File: doc/BRIEF.md
# Operand Address Specifier Decoder

This block takes in the address-specifier bytes of a variable-length instruction, one byte per clock, each one marked by a valid strobe. The first byte carries three fields: an addressing-form field, a register field and an operand-select field. Depending on those fields and on the addressing width (16-bit or 32-bit, chosen by `mode32`), the block then expects an optional scaled-index byte and a displacement of 0, 1, 2 or 4 bytes. Cycles in which valid is low are simply skipped, so the bytes of one specifier may arrive with gaps between them.

The block reads base and index register values through two combinational read ports. Each port addresses an 8-entry register file, numbered 0 to 7 in this order: accumulator, count, data, base, stack pointer, base pointer, source index, destination index. One cycle after the last specifier byte, `done` pulses for a single cycle. In that cycle the following are valid: the register field, a register-operand flag (or the computed effective address), and the total number of specifier bytes consumed. Opcode decoding, prefixes, segmentation and the memory access itself are left to neighbouring logic.

Top module: `eag_top`

## Requirements
- R1: The first byte is split into the addressing form in bits 7:6, the register field in bits 5:3 and the operand select in bits 2:0. `regField` reports bits 5:3 while `done` is high.
- R2: When the addressing form is 3, the operand is a register. `isRegOp` is 1, `rmField` names that register, `effAddr` is 0 and `byteCount` is 1.
- R3: In 32-bit mode, with operand select not 4, the base is the register named by operand select. Form 0 has no displacement, except operand select 5. Form 1 adds a sign-extended 8-bit displacement. Form 2 adds a 32-bit displacement.
- R4: In 32-bit mode, forms 0–2 with operand select 4 are followed by a scaled-index byte. That byte holds the scale in bits 7:6, the index in bits 5:3 and the base in bits 2:0. The address is base + (index << scale) + displacement.
- R5: An index code of 4 in the scaled-index byte means no index. A base code of 5 together with form 0 means no base, and a 4-byte displacement follows.
- R6: In 32-bit mode, form 0 with operand select 5 gives an address equal to a 4-byte displacement alone.
- R7: In 16-bit mode, operand select values 0 to 7 give the pairs base+srcidx, base+dstidx, bp+srcidx, bp+dstidx, srcidx, dstidx, bp and base (register numbers 3+6, 3+7, 5+6, 5+7, 6, 7, 5, 3). Form 1 adds a sign-extended 8-bit displacement and form 2 adds a 16-bit displacement.
- R8: In 16-bit mode, form 0 with operand select 6 gives a 2-byte direct address with no register.
- R9: The address is computed modulo 2^16 in 16-bit mode (`effAddr[31:16]` is 0) and modulo 2^32 in 32-bit mode.
- R10: Displacement bytes arrive least significant first. Cycles with valid low are skipped. `done` is high exactly in the cycle after the edge that accepts the last byte. `byteCount` then equals 1 + (scaled-index byte present) + displacement length.
- R11: After reset, `done` is 0 and `byteCount` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mode32 | input | 1 | 1 selects 32-bit addressing, 0 selects 16-bit; sampled with the first byte |
| byteValid | input | 1 | Qualifies `byteData` in this cycle |
| byteData | input | 8 | Specifier byte |
| regIdxA | output | 3 | Base register read address |
| regDataA | input | 32 | Base register value |
| regIdxB | output | 3 | Index register read address |
| regDataB | input | 32 | Index register value |
| done | output | 1 | One-cycle pulse: results valid |
| isRegOp | output | 1 | Operand is a register, not memory |
| regField | output | 3 | Register field of the first byte |
| rmField | output | 3 | Operand-select field of the first byte |
| effAddr | output | 32 | Effective address (0 for register operands) |
| byteCount | output | 3 | Specifier bytes consumed |

## Verification
The checks assume that `mode32` does not change between the first byte of a specifier and its `done` cycle. They also assume that the register read ports answer combinationally in the `done` cycle. The stimulus changes the mode only when the block is idle and holds the register file constant. The first byte of a new specifier is presented only after the previous `done` cycle has passed.

The sweeps cover every first-byte value in both widths and every scaled-index byte under forms 0–2. The register values are chosen so that sums carry past bit 15 and bit 31. Some specifiers have idle cycles inserted between their bytes.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_N  = 8;
  localparam int IDX_W  = $clog2(REG_N);
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 3;

  typedef enum logic [1:0] {ST_FIRST, ST_SIB, ST_DISP} phase_t;

  typedef struct packed {
    logic       capFirst;
    logic       capSib;
    logic       capDisp;
    logic [1:0] dispPos;
  } strobes_t;

  typedef struct packed {
    logic       regOp;
    logic       needSib;
    logic [2:0] dispLen;
  } firstInfo_t;

  typedef struct packed {
    logic [IDX_W-1:0] base;
    logic             hasBase;
    logic [IDX_W-1:0] idx;
    logic             hasIdx;
  } pair16_t;

  function automatic firstInfo_t decodeFirst(input logic [1:0] md, input logic [2:0] rm,
                                             input logic m32);
    firstInfo_t r;
    r.regOp   = (md == 2'd3);
    r.needSib = m32 && (md != 2'd3) && (rm == 3'd4);
    r.dispLen = 3'd0;
    if (md == 2'd1)      r.dispLen = 3'd1;
    else if (md == 2'd2) r.dispLen = m32 ? 3'd4 : 3'd2;
    else if (md == 2'd0) begin
      if (m32 && rm == 3'd5)       r.dispLen = 3'd4;
      else if (!m32 && rm == 3'd6) r.dispLen = 3'd2;
    end
    return r;
  endfunction

  function automatic logic [2:0] sibDispLen(input logic [1:0] md, input logic [2:0] base);
    if (md == 2'd1)                        return 3'd1;
    else if (md == 2'd2)                   return 3'd4;
    else if (base == 3'd5)                 return 3'd4;
    else                                   return 3'd0;
  endfunction

  function automatic pair16_t pair16(input logic [1:0] md, input logic [2:0] rm);
    pair16_t p;
    p.hasBase = 1'b1;
    p.hasIdx  = 1'b1;
    p.base    = 3'd3;
    p.idx     = 3'd6;
    case (rm)
      3'd0: begin p.base = 3'd3; p.idx = 3'd6; end
      3'd1: begin p.base = 3'd3; p.idx = 3'd7; end
      3'd2: begin p.base = 3'd5; p.idx = 3'd6; end
      3'd3: begin p.base = 3'd5; p.idx = 3'd7; end
      3'd4: begin p.base = 3'd6; p.hasIdx = 1'b0; end
      3'd5: begin p.base = 3'd7; p.hasIdx = 1'b0; end
      3'd6: begin p.base = 3'd5; p.hasIdx = 1'b0; p.hasBase = (md != 2'd0); end
      default: begin p.base = 3'd3; p.hasIdx = 1'b0; end
    endcase
    return p;
  endfunction
endpackage

// File: rtl/eag_ctrl.sv
module eag_ctrl
  import eag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              mode32,
  output strobes_t          stb,
  output logic              done,
  output logic [CNT_W-1:0]  byteCount
);
  phase_t     phase;
  logic [1:0] savedMod;
  logic [2:0] dispLeft;
  logic [1:0] dispPos;
  firstInfo_t firstNow;
  logic [2:0] sibLen;

  always_comb begin
    firstNow = decodeFirst(byteData[7:6], byteData[2:0], mode32);
    sibLen   = sibDispLen(savedMod, byteData[2:0]);
    stb.capFirst = byteValid && (phase == ST_FIRST);
    stb.capSib   = byteValid && (phase == ST_SIB);
    stb.capDisp  = byteValid && (phase == ST_DISP);
    stb.dispPos  = dispPos;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= ST_FIRST;
      savedMod  <= 2'd0;
      dispLeft  <= 3'd0;
      dispPos   <= 2'd0;
      done      <= 1'b0;
      byteCount <= '0;
    end else begin
      done <= 1'b0;
      if (byteValid) begin
        case (phase)
          ST_FIRST: begin
            byteCount <= 3'd1;
            savedMod  <= byteData[7:6];
            dispPos   <= 2'd0;
            if (firstNow.regOp || (!firstNow.needSib && firstNow.dispLen == 3'd0)) begin
              done <= 1'b1;
            end else if (firstNow.needSib) begin
              phase <= ST_SIB;
            end else begin
              phase    <= ST_DISP;
              dispLeft <= firstNow.dispLen;
            end
          end
          ST_SIB: begin
            byteCount <= byteCount + 3'd1;
            if (sibLen == 3'd0) begin
              done  <= 1'b1;
              phase <= ST_FIRST;
            end else begin
              phase    <= ST_DISP;
              dispLeft <= sibLen;
            end
          end
          ST_DISP: begin
            byteCount <= byteCount + 3'd1;
            dispPos   <= dispPos + 2'd1;
            dispLeft  <= dispLeft - 3'd1;
            if (dispLeft == 3'd1) begin
              done  <= 1'b1;
              phase <= ST_FIRST;
            end
          end
          default: phase <= ST_FIRST;
        endcase
      end
    end
  end
endmodule

// File: rtl/eag_dpath.sv
module eag_dpath
  import eag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              mode32,
  output logic [IDX_W-1:0]  regIdxA,
  input  logic [ADDR_W-1:0] regDataA,
  output logic [IDX_W-1:0]  regIdxB,
  input  logic [ADDR_W-1:0] regDataB,
  output logic [2:0]        regField,
  output logic [2:0]        rmField,
  output logic              isRegOp,
  output logic [ADDR_W-1:0] effAddr
);
  localparam int HALF_W = ADDR_W / 2;

  logic [1:0]        modQ;
  logic              m32Q;
  logic [IDX_W-1:0]  baseQ, idxQ;
  logic              hasBaseQ, hasIdxQ;
  logic [1:0]        scaleQ;
  logic [ADDR_W-1:0] dispQ;
  logic              disp8Q;
  pair16_t           p16;

  always_comb p16 = pair16(byteData[7:6], byteData[2:0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modQ <= 2'd0; regField <= 3'd0; rmField <= 3'd0; isRegOp <= 1'b0;
      m32Q <= 1'b0; baseQ <= '0; idxQ <= '0; hasBaseQ <= 1'b0; hasIdxQ <= 1'b0;
      scaleQ <= 2'd0; dispQ <= '0; disp8Q <= 1'b0;
    end else begin
      if (stb.capFirst) begin
        modQ     <= byteData[7:6];
        regField <= byteData[5:3];
        rmField  <= byteData[2:0];
        isRegOp  <= (byteData[7:6] == 2'd3);
        m32Q     <= mode32;
        scaleQ   <= 2'd0;
        dispQ    <= '0;
        disp8Q   <= (byteData[7:6] == 2'd1);
        if (mode32) begin
          baseQ    <= byteData[2:0];
          hasBaseQ <= !(byteData[7:6] == 2'd0 && byteData[2:0] == 3'd5);
          idxQ     <= '0;
          hasIdxQ  <= 1'b0;
        end else begin
          baseQ    <= p16.base;
          hasBaseQ <= p16.hasBase;
          idxQ     <= p16.idx;
          hasIdxQ  <= p16.hasIdx;
        end
      end
      if (stb.capSib) begin
        scaleQ   <= byteData[7:6];
        idxQ     <= byteData[5:3];
        hasIdxQ  <= (byteData[5:3] != 3'd4);
        baseQ    <= byteData[2:0];
        hasBaseQ <= !(byteData[2:0] == 3'd5 && modQ == 2'd0);
      end
      if (stb.capDisp) begin
        dispQ[{stb.dispPos, 3'b000} +: BYTE_W] <= byteData;
      end
    end
  end

  logic [ADDR_W-1:0] baseV, idxV, dispV, sumV;
  always_comb begin
    regIdxA = baseQ;
    regIdxB = idxQ;
    baseV   = hasBaseQ ? regDataA : '0;
    idxV    = hasIdxQ ? (regDataB << scaleQ) : '0;
    dispV   = disp8Q ? {{(ADDR_W-BYTE_W){dispQ[BYTE_W-1]}}, dispQ[BYTE_W-1:0]} : dispQ;
    sumV    = baseV + idxV + dispV;
    if (isRegOp)   effAddr = '0;
    else if (m32Q) effAddr = sumV;
    else           effAddr = {{HALF_W{1'b0}}, sumV[HALF_W-1:0]};
  end
endmodule

// File: rtl/eag_top.sv
module eag_top
  import eag_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        mode32,
  input  logic        byteValid,
  input  logic [7:0]  byteData,
  output logic [2:0]  regIdxA,
  input  logic [31:0] regDataA,
  output logic [2:0]  regIdxB,
  input  logic [31:0] regDataB,
  output logic        done,
  output logic        isRegOp,
  output logic [2:0]  regField,
  output logic [2:0]  rmField,
  output logic [31:0] effAddr,
  output logic [2:0]  byteCount
);
  strobes_t stb;

  eag_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .mode32(mode32), .stb(stb), .done(done), .byteCount(byteCount)
  );

  eag_dpath u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .byteData(byteData), .mode32(mode32),
    .regIdxA(regIdxA), .regDataA(regDataA), .regIdxB(regIdxB), .regDataB(regDataB),
    .regField(regField), .rmField(rmField), .isRegOp(isRegOp), .effAddr(effAddr)
  );
endmodule

// File: rtl/eag_chk.sv
module eag_chk (
  input logic        clk,
  input logic        rstN,
  input logic        mode32,
  input logic        byteValid,
  input logic        done,
  input logic        isRegOp,
  input logic [31:0] effAddr,
  input logic [2:0]  byteCount
);
  p_done_after_byte_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(byteValid));

  p_count_range_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (byteCount >= 3'd1 && byteCount <= 3'd6));

  p_regop_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    (done && isRegOp) |-> (byteCount == 3'd1 && effAddr == 32'd0));

  p_wrap16_r9: assert property (@(posedge clk) disable iff (!rstN)
    (done && !mode32) |-> (effAddr[31:16] == 16'd0));

  p_len16_r7: assert property (@(posedge clk) disable iff (!rstN)
    (done && !mode32) |-> (byteCount <= 3'd3));
endmodule

bind eag_top eag_chk u_chk (
  .clk(clk), .rstN(rstN), .mode32(mode32), .byteValid(byteValid), .done(done),
  .isRegOp(isRegOp), .effAddr(effAddr), .byteCount(byteCount)
);

// File: tb/sim_eag_top.sv
module sim_eag_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mode32 = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = 8'd0;
  logic [2:0]  regIdxA, regIdxB;
  logic [31:0] regDataA, regDataB;
  logic        done, isRegOp;
  logic [2:0]  regField, rmField, byteCount;
  logic [31:0] effAddr;
  logic [31:0] regs [8];

  int tests = 0;
  int fails = 0;
  int seq = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign regDataA = regs[regIdxA];
  assign regDataB = regs[regIdxB];

  eag_top u0 (
    .clk(clk), .rstN(rstN), .mode32(mode32), .byteValid(byteValid), .byteData(byteData),
    .regIdxA(regIdxA), .regDataA(regDataA), .regIdxB(regIdxB), .regDataB(regDataB),
    .done(done), .isRegOp(isRegOp), .regField(regField), .rmField(rmField),
    .effAddr(effAddr), .byteCount(byteCount)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    byteValid = 1'b1;
    byteData  = b;
    if (seq % 3 == 0) begin
      @(negedge clk);
      byteValid = 1'b0;
    end
  endtask

  task automatic runOne(input bit m32, input logic [7:0] mr, input logic [7:0] sb,
                        input logic [31:0] dv);
    logic [1:0] md;
    logic [2:0] rm;
    bit isR, useSib, special;
    int dl;
    logic [31:0] b, x, d, ea, mask;
    md = mr[7:6]; rm = mr[2:0];
    isR = (md == 2'd3); useSib = 0; special = 0; dl = 0; b = 0; x = 0;
    mask = m32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    if (isR) begin
      dl = 0;
    end else if (m32) begin
      useSib = (rm == 3'd4);
      if (useSib) begin
        if (!(sb[2:0] == 3'd5 && md == 2'd0)) b = regs[sb[2:0]]; else special = 1;
        if (sb[5:3] != 3'd4) x = regs[sb[5:3]] << sb[7:6]; else special = 1;
        dl = (md == 2'd1) ? 1 : (md == 2'd2) ? 4 : (sb[2:0] == 3'd5) ? 4 : 0;
      end else begin
        if (!(md == 2'd0 && rm == 3'd5)) b = regs[rm];
        dl = (md == 2'd1) ? 1 : (md == 2'd2) ? 4 : (rm == 3'd5) ? 4 : 0;
      end
    end else begin
      case (rm)
        3'd0: begin b = regs[3]; x = regs[6]; end
        3'd1: begin b = regs[3]; x = regs[7]; end
        3'd2: begin b = regs[5]; x = regs[6]; end
        3'd3: begin b = regs[5]; x = regs[7]; end
        3'd4: b = regs[6];
        3'd5: b = regs[7];
        3'd6: b = (md == 2'd0) ? 32'd0 : regs[5];
        default: b = regs[3];
      endcase
      dl = (md == 2'd1) ? 1 : (md == 2'd2) ? 2 : (rm == 3'd6) ? 2 : 0;
    end
    case (dl)
      1: d = {{24{dv[7]}}, dv[7:0]};
      2: d = {16'd0, dv[15:0]};
      4: d = dv;
      default: d = 32'd0;
    endcase
    ea = isR ? 32'd0 : ((b + x + d) & mask);

    seq++;
    @(negedge clk);
    mode32 = m32;
    byteValid = 1'b0;
    sendByte(mr);
    if (useSib) sendByte(sb);
    for (int k = 0; k < dl; k++) sendByte(dv[8*k +: 8]);
    if (seq % 3 != 0) begin
      @(negedge clk);
      byteValid = 1'b0;
    end
    chk("R10 done", {31'd0, done}, 32'd1);
    chk("R10 count", {29'd0, byteCount}, 1 + (useSib ? 1 : 0) + dl);
    chk("R1 regField", {29'd0, regField}, {29'd0, mr[5:3]});
    if (isR) begin
      chk("R2 regop", {31'd0, isRegOp}, 32'd1);
      chk("R2 rmField", {29'd0, rmField}, {29'd0, rm});
      chk("R2 addr", effAddr, 32'd0);
    end else if (!m32) begin
      chk((md == 2'd0 && rm == 3'd6) ? "R8 direct16" : "R7 addr16", effAddr, ea);
      chk("R9 wrap16", {16'd0, effAddr[31:16]}, 32'd0);
    end else if (useSib) begin
      chk(special ? "R5 sib special" : "R4 sib addr", effAddr, ea);
    end else begin
      chk((md == 2'd0 && rm == 3'd5) ? "R6 disp only" : "R3 addr32", effAddr, ea);
    end
    @(negedge clk);
    chk("R10 pulse", {31'd0, done}, 32'd0);
  endtask

  initial begin
    regs[0] = 32'hFFFF_FF00; regs[1] = 32'h0000_1234;
    regs[2] = 32'h8000_0001; regs[3] = 32'h0001_FFF0;
    regs[4] = 32'hC0DE_0004; regs[5] = 32'h0000_FFFE;
    regs[6] = 32'h7FFF_FFFF; regs[7] = 32'h1357_9BDF;
    repeat (3) @(negedge clk);
    chk("R11 done", {31'd0, done}, 32'd0);
    chk("R11 count", {29'd0, byteCount}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      for (int v = 0; v < 256; v++) begin
        logic [7:0] mr;
        mr = v[7:0];
        runOne(m[0], mr, mr * 8'd37 + 8'd5,
               {mr, ~mr, mr ^ 8'h5A, mr + 8'h81});
      end
    end
    for (int md = 0; md < 3; md++) begin
      for (int s = 0; s < 256; s++) begin
        logic [7:0] sb;
        sb = s[7:0];
        runOne(1'b1, {md[1:0], sb[2:0], 3'd4}, sb,
               {sb ^ 8'hC3, sb, 8'h80 | sb, ~sb});
      end
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule